// File: doc/BRIEF.md
# Edge-Triggered Interrupt Request Unit

This unit gathers interrupt requests for a small processor. One external pin and three internal sources each have a vector. The external pin responds to a rising or a falling edge, selected by a configuration input. The three internal sources present one-cycle request pulses that are already synchronous to the clock. Four key-scan inputs are quasi-interrupts. A falling edge on any of them sets one shared flag. That flag can wake the device, but it never produces a vector.

The external pin and the key-scan pins are asynchronous. Each passes through a two-flop synchronizer and then a width filter. A new level is accepted only after it has been seen on a programmable number of consecutive clock samples. Shorter glitches are dropped. Each vectored source has a pending flag and an enable. The unit presents the index of the highest-priority request that is both pending and enabled. An acknowledge clears the request being presented. A wake output is combinational, so it remains usable while the processor clock is stopped.

Top module: `edge_irq_unit`

## Requirements
- R1: After reset all pending flags and the key flag are clear, and irq_valid_o and wake_o are 0.
- R2: A level change on ext_pin_i or key_i is accepted only after the two-flop synchronizer, and only once the new level has held for max(filt_len_i,1) consecutive clock samples. A change that reverts sooner produces no event. An accepted change sets its flag two cycles after the filter reaches its count.
- R3: ext_rise_sel_i=1 makes an accepted rising edge of ext_pin_i set the external pending flag. ext_rise_sel_i=0 makes an accepted falling edge set it. The other edge is ignored.
- R4: An accepted falling edge on any key_i bit sets key_flag_o. Rising edges on key_i are ignored. Key events never set a vectored pending flag.
- R5: int_req_i[k]=1 on a clock edge sets the pending flag of vector k+1, visible after that edge.
- R6: Vector ids are 0 for the external pin and k+1 for int_req_i[k]. Among pending flags whose vec_en_i bit is 1, the lowest id is presented on irq_id_o, and irq_valid_o is 1.
- R7: A pending flag whose enable is 0 is kept but not presented. Setting its enable presents it without a new event.
- R8: ack_i while irq_valid_o is 1 clears the presented flag at the clock edge. A set of the same flag on that edge wins.
- R9: key_flag_o clears only on key_clr_i. A key event on the same edge wins.
- R10: wake_o is 1 exactly when some enabled vectored flag is pending, or when key_flag_o and key_en_i are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_pin_i | input | 1 | External interrupt pin (asynchronous) |
| ext_rise_sel_i | input | 1 | 1: rising edge active, 0: falling edge active |
| int_req_i | input | N_INT | Internal request pulses |
| key_i | input | N_KEY | Key-scan pins (asynchronous) |
| filt_len_i | input | CNT_W | Minimum stable samples; 0 acts as 1 |
| vec_en_i | input | N_INT+1 | Per-vector enable, bit = vector id |
| key_en_i | input | 1 | Lets the key flag drive wake_o |
| ack_i | input | 1 | Acknowledge of the presented vector |
| key_clr_i | input | 1 | Clears the key flag |
| irq_valid_o | output | 1 | An enabled request is pending |
| irq_id_o | output | $clog2(N_INT+1) | Id of the highest-priority enabled pending vector |
| key_flag_o | output | 1 | Quasi-interrupt flag |
| wake_o | output | 1 | Wake request |

## Verification
The hardest cases to reach from the ports are glitches that revert exactly one sample short of the filter threshold, and an acknowledge that lands on the same edge as a new set of the presented flag. The stimulus holds the pins for exact cycle counts around the threshold, for several filt_len_i values including 0. It then pulses an internal request in the acknowledge cycle. A behavioural reference model, compared every cycle, covers a long random phase of pin toggles, pulses, enables and acknowledges.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_evt_t;
endpackage

// File: rtl/irq_pin_filter.sv
module irq_pin_filter
  import irq_pkg::*;
#(
  parameter int   CNT_W   = 4,
  parameter logic RST_LVL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic [CNT_W-1:0] len_i,
  output edge_evt_t        evt_o
);
  localparam int CW = CNT_W + 1;

  logic          sync1_q, sync2_q, lvl_q;
  logic [CW-1:0] cnt_q, thr, cnt_inc;
  edge_evt_t     evt_q;

  assign thr     = (len_i == '0) ? CW'(1) : {1'b0, len_i};
  assign cnt_inc = cnt_q + CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= RST_LVL;
      sync2_q <= RST_LVL;
      lvl_q   <= RST_LVL;
      cnt_q   <= '0;
      evt_q   <= '0;
    end else begin
      sync1_q <= pin_i;
      sync2_q <= sync1_q;
      evt_q   <= '0;
      if (sync2_q == lvl_q) begin
        cnt_q <= '0;
      end else if (cnt_inc >= thr) begin
        lvl_q      <= sync2_q;
        cnt_q      <= '0;
        evt_q.rise <= sync2_q;
        evt_q.fall <= ~sync2_q;
      end else begin
        cnt_q <= cnt_inc;
      end
    end
  end

  assign evt_o = evt_q;

  a_r2_level_needs_mismatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lvl_q) |-> $past(sync2_q != lvl_q));
  a_r2_single_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({evt_q.rise, evt_q.fall}));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N    = 4,
  parameter int ID_W = 2
) (
  input  logic [N-1:0]    req_i,
  output logic            valid_o,
  output logic [ID_W-1:0] id_o
);
  always_comb begin
    id_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) id_o = ID_W'(i);
    end
  end
  assign valid_o = |req_i;

  always_comb begin
    if (valid_o) a_r6_pick_is_pending: assert (req_i[id_o]);
  end
endmodule

// File: rtl/edge_irq_unit.sv
module edge_irq_unit
  import irq_pkg::*;
#(
  parameter int N_INT = 3,
  parameter int N_KEY = 4,
  parameter int CNT_W = 4,
  localparam int N_VEC = N_INT + 1,
  localparam int ID_W  = (N_VEC > 1) ? $clog2(N_VEC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_pin_i,
  input  logic             ext_rise_sel_i,
  input  logic [N_INT-1:0] int_req_i,
  input  logic [N_KEY-1:0] key_i,
  input  logic [CNT_W-1:0] filt_len_i,
  input  logic [N_VEC-1:0] vec_en_i,
  input  logic             key_en_i,
  input  logic             ack_i,
  input  logic             key_clr_i,
  output logic             irq_valid_o,
  output logic [ID_W-1:0]  irq_id_o,
  output logic             key_flag_o,
  output logic             wake_o
);
  localparam int N_PIN = N_KEY + 1;

  logic [N_PIN-1:0] pins;
  edge_evt_t        evt [N_PIN];
  logic [N_VEC-1:0] pend_q, set_vec, ack_vec, live;
  logic [N_KEY-1:0] key_fall, key_rise;
  logic             key_set, key_rise_any, key_flag_q, ext_set;

  assign pins = {key_i, ext_pin_i};

  for (genvar p = 0; p < N_PIN; p++) begin : g_filt
    irq_pin_filter #(.CNT_W(CNT_W), .RST_LVL(1'b1)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pin_i (pins[p]),
      .len_i (filt_len_i),
      .evt_o (evt[p])
    );
  end

  for (genvar k = 0; k < N_KEY; k++) begin : g_key
    assign key_fall[k] = evt[k+1].fall;
    assign key_rise[k] = evt[k+1].rise;
  end
  assign key_set      = |key_fall;
  assign key_rise_any = |key_rise;

  assign ext_set = ext_rise_sel_i ? evt[0].rise : evt[0].fall;
  assign set_vec = {int_req_i, ext_set};
  assign live    = pend_q & vec_en_i;

  irq_prio_pick #(.N(N_VEC), .ID_W(ID_W)) u_pick (
    .req_i  (live),
    .valid_o(irq_valid_o),
    .id_o   (irq_id_o)
  );

  always_comb begin
    ack_vec = '0;
    if (ack_i && irq_valid_o) ack_vec[irq_id_o] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= '0;
      key_flag_q <= 1'b0;
    end else begin
      pend_q     <= (pend_q & ~ack_vec) | set_vec;
      key_flag_q <= key_set | (key_flag_q & ~key_clr_i);
    end
  end

  assign key_flag_o = key_flag_q;
  assign wake_o     = (|live) | (key_flag_q & key_en_i);

  a_r8_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_valid_o && !set_vec[irq_id_o]) |=> !pend_q[$past(irq_id_o)]);
  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_valid_o && set_vec[irq_id_o]) |=> pend_q[$past(irq_id_o)]);
  a_r9_key_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_clr_i && !key_set) |=> !key_flag_q);
  a_r4_key_no_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_set && set_vec == '0 && !ack_i) |=> pend_q == $past(pend_q));
  a_r4_key_rise_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_rise_any && !key_set && !key_flag_q) |=> !key_flag_q);
  a_r10_valid_wakes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> wake_o);
endmodule

// File: tb/edge_irq_unit_tb.sv
module edge_irq_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_INT = 3, N_KEY = 4, CNT_W = 4;
  localparam int N_VEC = N_INT + 1, N_PIN = N_KEY + 1;

  logic clk = 0, rst_ni = 0;
  logic ext_pin = 1, ext_rise_sel = 0, key_en = 0, ack = 0, key_clr = 0;
  logic [N_INT-1:0] int_req = '0;
  logic [N_KEY-1:0] key = '1;
  logic [CNT_W-1:0] filt_len = 4'd3;
  logic [N_VEC-1:0] vec_en = '1;
  logic irq_valid, key_flag, wake;
  logic [1:0] irq_id;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";

  // reference model state
  bit m_s1[N_PIN], m_s2[N_PIN], m_lvl[N_PIN], m_rise[N_PIN], m_fall[N_PIN];
  int m_cnt[N_PIN];
  bit m_pend[N_VEC];
  bit m_key;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_irq_unit #(.N_INT(N_INT), .N_KEY(N_KEY), .CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ext_pin_i(ext_pin), .ext_rise_sel_i(ext_rise_sel),
    .int_req_i(int_req), .key_i(key), .filt_len_i(filt_len), .vec_en_i(vec_en),
    .key_en_i(key_en), .ack_i(ack), .key_clr_i(key_clr),
    .irq_valid_o(irq_valid), .irq_id_o(irq_id), .key_flag_o(key_flag), .wake_o(wake));

  function automatic bit pin_val(int p);
    return (p == 0) ? ext_pin : key[p-1];
  endfunction

  function automatic bit m_valid();
    for (int v = 0; v < N_VEC; v++) if (m_pend[v] && vec_en[v]) return 1;
    return 0;
  endfunction

  function automatic int m_id();
    for (int v = 0; v < N_VEC; v++) if (m_pend[v] && vec_en[v]) return v;
    return 0;
  endfunction

  function automatic bit m_wake();
    return m_valid() || (m_key && key_en);
  endfunction

  task automatic model_reset();
    for (int p = 0; p < N_PIN; p++) begin
      m_s1[p] = 1; m_s2[p] = 1; m_lvl[p] = 1; m_rise[p] = 0; m_fall[p] = 0; m_cnt[p] = 0;
    end
    for (int v = 0; v < N_VEC; v++) m_pend[v] = 0;
    m_key = 0;
  endtask

  task automatic model_edge();
    int thr;
    bit nrise[N_PIN], nfall[N_PIN];
    bit kset, ext_set, valid;
    int id;
    thr = (filt_len == 0) ? 1 : filt_len;
    valid = m_valid();
    id = m_id();
    ext_set = ext_rise_sel ? m_rise[0] : m_fall[0];
    kset = 0;
    for (int p = 1; p < N_PIN; p++) kset |= m_fall[p];
    if (ack && valid) m_pend[id] = 0;
    if (ext_set) m_pend[0] = 1;
    for (int k = 0; k < N_INT; k++) if (int_req[k]) m_pend[k+1] = 1;
    m_key = kset || (m_key && !key_clr);
    for (int p = 0; p < N_PIN; p++) begin
      nrise[p] = 0; nfall[p] = 0;
      if (m_s2[p] == m_lvl[p]) m_cnt[p] = 0;
      else if (m_cnt[p] + 1 >= thr) begin
        m_lvl[p] = m_s2[p]; m_cnt[p] = 0;
        nrise[p] = m_s2[p]; nfall[p] = !m_s2[p];
      end else m_cnt[p] = m_cnt[p] + 1;
      m_s2[p] = m_s1[p];
      m_s1[p] = pin_val(p);
      m_rise[p] = nrise[p]; m_fall[p] = nfall[p];
    end
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(irq_valid == m_valid(), cur_req, "irq_valid", irq_valid, m_valid());
    if (m_valid()) chk(irq_id == m_id(), cur_req, "irq_id", irq_id, m_id());
    chk(key_flag == m_key, cur_req, "key_flag", key_flag, m_key);
    chk(wake == m_wake(), cur_req, "wake", wake, m_wake());
  endtask

  // one clock: inputs already applied; model the edge, then compare after it
  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      model_edge();
      @(negedge clk);
      cycles++;
      compare();
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    chk(!irq_valid && !key_flag && !wake, "R1", "reset outputs", {irq_valid, key_flag, wake}, 0);
    compare();

    // R2 glitch one sample short of threshold 3
    cur_req = "R2";
    ext_rise_sel = 0;
    ext_pin = 0; step(2);
    ext_pin = 1; step(8);
    chk(!irq_valid, "R2", "short glitch ignored", irq_valid, 0);
    ext_pin = 0; step(8);
    chk(irq_valid && irq_id == 0, "R2", "falling accepted id", irq_id, 0);

    // R8 acknowledge
    cur_req = "R8";
    ack = 1; step(1); ack = 0;
    chk(!irq_valid, "R8", "ack cleared", irq_valid, 0);
    step(2);

    // R3 rising selected
    cur_req = "R3";
    ext_rise_sel = 1;
    ext_pin = 1; step(8);
    chk(irq_valid && irq_id == 0, "R3", "rising accepted", irq_valid, 1);
    ack = 1; step(1); ack = 0;
    ext_pin = 0; step(8);
    chk(!irq_valid, "R3", "falling ignored when rise selected", irq_valid, 0);

    // R4 key events
    cur_req = "R4";
    key[2] = 0; step(2); key[2] = 1; step(8);
    chk(!key_flag, "R4", "key glitch ignored", key_flag, 0);
    key[2] = 0; step(8);
    chk(key_flag && !irq_valid, "R4", "key flag no vector", key_flag, 1);

    // R10 wake from key flag
    cur_req = "R10";
    chk(!wake, "R10", "wake masked by key_en", wake, 0);
    key_en = 1; step(1);
    chk(wake, "R10", "wake from key flag", wake, 1);

    // R9 clear, then rising key ignored
    cur_req = "R9";
    key_clr = 1; step(1); key_clr = 0;
    chk(!key_flag, "R9", "key flag cleared", key_flag, 0);
    key[2] = 1; step(8);
    chk(!key_flag, "R4", "key rise ignored", key_flag, 0);
    key_en = 0;

    // R5/R6 priority with all sources
    cur_req = "R6";
    int_req = 3'b111; step(1); int_req = '0;
    chk(irq_valid && irq_id == 1, "R5", "internal pulse sets id1", irq_id, 1);
    ack = 1; step(1);
    chk(irq_id == 2, "R6", "next id", irq_id, 2);
    step(1);
    chk(irq_id == 3, "R6", "last id", irq_id, 3);
    step(1); ack = 0;
    chk(!irq_valid, "R6", "all drained", irq_valid, 0);

    // R7 disabled pending held
    cur_req = "R7";
    vec_en = 4'b1011; int_req = 3'b010; step(1); int_req = '0; step(3);
    chk(!irq_valid, "R7", "disabled not presented", irq_valid, 0);
    vec_en = '1; step(1);
    chk(irq_valid && irq_id == 2, "R7", "enabled presents", irq_id, 2);
    ack = 1; step(1); ack = 0;

    // R8 set on ack edge wins
    cur_req = "R8";
    int_req = 3'b001; step(1);
    ack = 1; step(1); ack = 0; int_req = '0;
    chk(irq_valid && irq_id == 1, "R8", "set wins over ack", irq_id, 1);
    ack = 1; step(1); ack = 0;

    // R2 filt_len 0 and 1 behave as 1
    cur_req = "R2";
    filt_len = 0; ext_rise_sel = 1;
    ext_pin = 1; step(1); ext_pin = 0; step(6);
    chk(irq_valid, "R2", "one-sample pulse accepted at len 0", irq_valid, 1);
    ack = 1; step(1); ack = 0;
    filt_len = 1;
    ext_pin = 1; step(1); ext_pin = 0; step(6);
    chk(irq_valid, "R2", "one-sample pulse accepted at len 1", irq_valid, 1);
    ack = 1; step(1); ack = 0;

    // random phase
    cur_req = "R6";
    for (int i = 0; i < 3000; i++) begin
      filt_len = 4'($urandom_range(0, 5));
      if ($urandom_range(0, 9) == 0) ext_pin = ~ext_pin;
      if ($urandom_range(0, 9) == 0) key[$urandom_range(0, N_KEY-1)] ^= 1'b1;
      int_req = ($urandom_range(0, 7) == 0) ? 3'($urandom) : '0;
      ack = ($urandom_range(0, 2) == 0);
      key_clr = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 31) == 0) vec_en = 4'($urandom);
      if ($urandom_range(0, 31) == 0) ext_rise_sel = ~ext_rise_sel;
      key_en = ($urandom_range(0, 1) == 0);
      step(1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule